// File: doc/BRIEF.md
# Voltage and Clock Transition Sequencer

This block moves a circuit from one performance level to another without ever letting the clock outrun the supply. It gets a level index through a valid/ready handshake. It reads the supply code, the clock divider and the PLL multiplier for that level from a small table that software can write. It then drives the supply request and the clock settings one after the other. A higher index means a faster level. When the level goes up, the block raises the supply first, waits for the regulator to report that it has settled, and only then changes the clock. When the level goes down, the block slows the clock first. It then lowers the supply while the circuit keeps running at the reduced clock.

If the new level keeps the current PLL multiplier, only the divider is rewritten and no PLL lock wait is needed. If the multiplier changes, the divider and the multiplier are written together, and the block waits for the PLL lock input before it goes on. Every supply wait is bounded by a programmable cycle limit. If the limit runs out, the block sets an error flag and finishes. On an upward move that runs out, the clock stays at its old setting.

Top module: `dvfs_sequencer`

## Requirements
- R1: The supply code output and the clock outputs (divider or multiplier) never change in the same clock cycle.
- R2: On a request for a higher index, the supply code changes first. The divider and multiplier change only in the cycle after `vreg_settled_i` was seen high in the supply wait.
- R3: On a request for a lower index, the divider and multiplier change first, and the supply code changes only after that.
- R4: If the target multiplier equals the current one, only the divider changes and no lock wait takes place. From acceptance to done, `busy_o` is high for D+3 cycles, where D is the number of wait cycles before settle (see R6).
- R5: If the target multiplier differs, the divider and multiplier change together. The sequence does not continue until `pll_lock_i` is seen high. Each lock wait adds L+1 busy cycles, where L is the lock delay counted in the same way as D.
- R6: The supply wait cycles are numbered from 0. The wait ends at the first wait cycle k in which `vreg_settled_i` is high. It also ends without settle at k = `settle_limit_i`. If both happen in the same cycle, settle wins and no error is raised.
- R7: An expired wait sets `timeout_err_o`. On an upward move it then finishes with the divider and multiplier unchanged, so busy lasts `settle_limit_i`+2 cycles. On a downward move the lowered clock stays in place. The flag clears when the next request is accepted.
- R8: `req_ready_o` is high only while the block is idle. A request held valid during a transition is not taken, either then or in the done cycle.
- R9: A request for the current level completes with `done_o` in the cycle after acceptance. It has zero busy cycles and changes no output.
- R10: While reset is asserted, the outputs carry the reset table entry (supply code 0x40, divider 1, multiplier 10), `done_o` is high, and `req_ready_o` and `timeout_err_o` are low.
- R11: A table write becomes visible to requests accepted after it. The entry of a request is captured when the request is accepted, so writing that entry during the transition does not change the result.
- R12: `done_o` is a one-cycle pulse that ends every transition. `busy_o` is high from the cycle after acceptance until `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | LVL_W | Level entry to write |
| tbl_vcode_i | input | VCODE_W | Supply code to store |
| tbl_div_i | input | DIV_W | Divider value to store |
| tbl_mult_i | input | MULT_W | PLL multiplier to store |
| settle_limit_i | input | TMO_W | Last supply wait cycle index before timeout |
| req_valid_i | input | 1 | Level request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_level_i | input | LVL_W | Requested level index, higher is faster |
| vreg_code_o | output | VCODE_W | Supply code to the regulator |
| vreg_settled_i | input | 1 | Regulator reports the supply is settled |
| clk_div_o | output | DIV_W | Clock divider setting |
| pll_mult_o | output | MULT_W | PLL multiplier setting |
| pll_lock_i | input | 1 | PLL lock indication |
| busy_o | output | 1 | Transition in progress |
| done_o | output | 1 | One-cycle end-of-transition pulse |
| timeout_err_o | output | 1 | Last supply wait timed out |

## Verification
The case that needs care is the supply wait cycle where settle and the timeout limit arrive together. The regulator model raises `vreg_settled_i` exactly `settle_limit_i` cycles into the wait. The result must show the new clock and a clear error flag, which shows that settle wins. The next case moves the settle one cycle later, and the bench expects the timeout path with the frequency held. A scoreboard gives every request an expected final state, busy length and first-changed output. A monitor checks each of these at every `done_o` pulse.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_VUP_REQ  = 3'd1,
    ST_VUP_WAIT = 3'd2,
    ST_F_SET    = 3'd3,
    ST_PLL_WAIT = 3'd4,
    ST_VDN_REQ  = 3'd5,
    ST_VDN_WAIT = 3'd6,
    ST_DONE     = 3'd7
  } seq_state_e;

endpackage

// File: rtl/dvfs_rst_sync.sv
module dvfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dvfs_level_table.sv
module dvfs_level_table #(
  parameter int LEVELS    = 8,
  parameter int VCODE_W   = 8,
  parameter int DIV_W     = 4,
  parameter int MULT_W    = 6,
  parameter int RST_VCODE = 64,
  parameter int RST_DIV   = 1,
  parameter int RST_MULT  = 10,
  localparam int LVL_W    = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [LVL_W-1:0]   waddr,
  input  logic [VCODE_W-1:0] wvcode,
  input  logic [DIV_W-1:0]   wdiv,
  input  logic [MULT_W-1:0]  wmult,
  input  logic [LVL_W-1:0]   raddr,
  output logic [VCODE_W-1:0] rvcode,
  output logic [DIV_W-1:0]   rdiv,
  output logic [MULT_W-1:0]  rmult
);
  logic [VCODE_W-1:0] vcode_q [LEVELS];
  logic [DIV_W-1:0]   div_q   [LEVELS];
  logic [MULT_W-1:0]  mult_q  [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == LVL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vcode_q[g] <= VCODE_W'(RST_VCODE);
        div_q[g]   <= DIV_W'(RST_DIV);
        mult_q[g]  <= MULT_W'(RST_MULT);
      end else if (hit) begin
        vcode_q[g] <= wvcode;
        div_q[g]   <= wdiv;
        mult_q[g]  <= wmult;
      end
    end
  end

  assign rvcode = vcode_q[raddr];
  assign rdiv   = div_q[raddr];
  assign rmult  = mult_q[raddr];

  // R11: a write is visible in the addressed entry on the next cycle
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (vcode_q[$past(waddr)] == $past(wvcode) &&
            div_q[$past(waddr)] == $past(wdiv) &&
            mult_q[$past(waddr)] == $past(wmult)));
endmodule

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr || run;
  assign cnt_d  = clr ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == limit);

  // R6: a wait that starts right after a clear reaches the limit index only after limit cycles
  p_first_wait_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr ##1 run) |-> (expired == (limit == '0)));
endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer
  import dvfs_seq_pkg::*;
#(
  parameter int LEVELS    = 8,
  parameter int VCODE_W   = 8,
  parameter int DIV_W     = 4,
  parameter int MULT_W    = 6,
  parameter int TMO_W     = 8,
  parameter int RST_VCODE = 64,
  parameter int RST_DIV   = 1,
  parameter int RST_MULT  = 10,
  localparam int LVL_W    = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we_i,
  input  logic [LVL_W-1:0]   tbl_addr_i,
  input  logic [VCODE_W-1:0] tbl_vcode_i,
  input  logic [DIV_W-1:0]   tbl_div_i,
  input  logic [MULT_W-1:0]  tbl_mult_i,
  input  logic [TMO_W-1:0]   settle_limit_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LVL_W-1:0]   req_level_i,
  output logic [VCODE_W-1:0] vreg_code_o,
  input  logic               vreg_settled_i,
  output logic [DIV_W-1:0]   clk_div_o,
  output logic [MULT_W-1:0]  pll_mult_o,
  input  logic               pll_lock_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_err_o
);
  logic rst_sync_n;

  dvfs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  logic [VCODE_W-1:0] rd_vcode;
  logic [DIV_W-1:0]   rd_div;
  logic [MULT_W-1:0]  rd_mult;

  dvfs_level_table #(
    .LEVELS(LEVELS), .VCODE_W(VCODE_W), .DIV_W(DIV_W), .MULT_W(MULT_W),
    .RST_VCODE(RST_VCODE), .RST_DIV(RST_DIV), .RST_MULT(RST_MULT)
  ) u_table (
    .clk(clk), .rst_n(rst_sync_n),
    .we(tbl_we_i), .waddr(tbl_addr_i),
    .wvcode(tbl_vcode_i), .wdiv(tbl_div_i), .wmult(tbl_mult_i),
    .raddr(req_level_i),
    .rvcode(rd_vcode), .rdiv(rd_div), .rmult(rd_mult));

  seq_state_e         state_q, state_d;
  logic [LVL_W-1:0]   cur_lvl_q, tgt_lvl_q;
  logic [VCODE_W-1:0] tgt_v_q, vcode_q;
  logic [DIV_W-1:0]   tgt_d_q, div_q;
  logic [MULT_W-1:0]  tgt_m_q, mult_q;
  logic               up_q, err_q;

  logic tmr_clr, tmr_run, tmr_expired;
  logic accept, load_v, load_f, err_set, in_wait, wait_end, pll_change;

  assign in_wait    = (state_q == ST_VUP_WAIT) || (state_q == ST_VDN_WAIT);
  assign tmr_clr    = (state_q == ST_VUP_REQ) || (state_q == ST_VDN_REQ);
  assign tmr_run    = in_wait;
  assign wait_end   = vreg_settled_i || tmr_expired;
  assign accept     = (state_q == ST_IDLE) && req_valid_i;
  assign load_v     = tmr_clr;
  assign load_f     = (state_q == ST_F_SET);
  assign err_set    = in_wait && !vreg_settled_i && tmr_expired;
  assign pll_change = (tgt_m_q != mult_q);

  dvfs_settle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .clr(tmr_clr), .run(tmr_run),
    .limit(settle_limit_i), .expired(tmr_expired));

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (req_level_i == cur_lvl_q)     state_d = ST_DONE;
        else if (req_level_i > cur_lvl_q) state_d = ST_VUP_REQ;
        else                              state_d = ST_F_SET;
      end
      ST_VUP_REQ:  state_d = ST_VUP_WAIT;
      ST_VUP_WAIT: if (vreg_settled_i)   state_d = ST_F_SET;
                   else if (tmr_expired) state_d = ST_DONE;
      ST_F_SET:    if (pll_change) state_d = ST_PLL_WAIT;
                   else            state_d = up_q ? ST_DONE : ST_VDN_REQ;
      ST_PLL_WAIT: if (pll_lock_i) state_d = up_q ? ST_DONE : ST_VDN_REQ;
      ST_VDN_REQ:  state_d = ST_VDN_WAIT;
      ST_VDN_WAIT: if (wait_end) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_DONE;
    else             state_q <= state_d;
  end

  // captured target entry
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tgt_lvl_q <= '0;
      tgt_v_q   <= VCODE_W'(RST_VCODE);
      tgt_d_q   <= DIV_W'(RST_DIV);
      tgt_m_q   <= MULT_W'(RST_MULT);
      up_q      <= 1'b0;
    end else if (accept) begin
      tgt_lvl_q <= req_level_i;
      tgt_v_q   <= rd_vcode;
      tgt_d_q   <= rd_div;
      tgt_m_q   <= rd_mult;
      up_q      <= (req_level_i > cur_lvl_q);
    end
  end

  // supply request
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  vcode_q <= VCODE_W'(RST_VCODE);
    else if (load_v)  vcode_q <= tgt_v_q;
  end

  // clock settings and the level the clock now reflects
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_q     <= DIV_W'(RST_DIV);
      mult_q    <= MULT_W'(RST_MULT);
      cur_lvl_q <= '0;
    end else if (load_f) begin
      div_q     <= tgt_d_q;
      mult_q    <= tgt_m_q;
      cur_lvl_q <= tgt_lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   err_q <= 1'b0;
    else if (accept)   err_q <= 1'b0;
    else if (err_set)  err_q <= 1'b1;
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign busy_o        = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o        = (state_q == ST_DONE);
  assign vreg_code_o   = vcode_q;
  assign clk_div_o     = div_q;
  assign pll_mult_o    = mult_q;
  assign timeout_err_o = err_q;

  p_split_change_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!$stable(vcode_q) && (!$stable(div_q) || !$stable(mult_q))));

  p_up_settled_first_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_F_SET && up_q) |-> $past(vreg_settled_i));

  p_down_clock_first_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_VDN_REQ) |-> (div_q == tgt_d_q && mult_q == tgt_m_q));

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_PLL_WAIT && !pll_lock_i) |=> (state_q == ST_PLL_WAIT));

  p_timeout_flag_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(err_q) |-> $past(tmr_expired && !vreg_settled_i));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready_o |-> !busy_o && !done_o);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);
endmodule

// File: tb/dvfs_sequencer_tb_top.sv
module dvfs_sequencer_tb_top;
  localparam int LEVELS = 8, VW = 8, DW = 4, MW = 6, TW = 8;
  localparam int RV = 64, RD = 1, RM = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_addr = '0;
  logic [VW-1:0] tbl_v = '0;
  logic [DW-1:0] tbl_d = '0;
  logic [MW-1:0] tbl_m = '0;
  logic [TW-1:0] tmo = 8'd12;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_level = '0;
  logic [VW-1:0] vcode;
  logic settled = 1'b1, lock = 1'b1;
  logic [DW-1:0] cdiv;
  logic [MW-1:0] pmult;
  logic busy, done, err;

  always #4 clk = ~clk;

  dvfs_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_vcode_i(tbl_v), .tbl_div_i(tbl_d), .tbl_mult_i(tbl_m),
    .settle_limit_i(tmo), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_level_i(req_level), .vreg_code_o(vcode), .vreg_settled_i(settled),
    .clk_div_o(cdiv), .pll_mult_o(pmult), .pll_lock_i(lock),
    .busy_o(busy), .done_o(done), .timeout_err_o(err));

  int n_cmp = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // regulator and PLL models
  int settle_d = 2, lock_d = 2, scnt = 0, lcnt = 0;
  logic [VW-1:0] last_v;
  logic [MW-1:0] last_m;
  always @(negedge clk) begin
    if (!rst_n) begin
      last_v = vcode; last_m = pmult; settled = 1'b1; lock = 1'b1;
    end else begin
      if (vcode != last_v) begin
        last_v = vcode; settled = 1'b0; scnt = settle_d;
      end else if (!settled && scnt > 0) begin
        scnt--; if (scnt == 0) settled = 1'b1;
      end
      if (pmult != last_m) begin
        last_m = pmult; lock = 1'b0; lcnt = lock_d;
      end else if (!lock && lcnt > 0) begin
        lcnt--; if (lcnt == 0) lock = 1'b1;
      end
    end
  end

  typedef struct { int v; int d; int m; int e; int busy; int order; } exp_t;
  exp_t sb_q[$];

  int mv[LEVELS], md[LEVELS], mm[LEVELS];
  int cur_l = 0, cv = RV, cd = RD, cm = RM;

  // monitor
  bit mon_en = 0, joint = 0;
  int busy_cnt = 0, first = 0;
  logic [VW-1:0] pv; logic [DW-1:0] pd; logic [MW-1:0] pm;
  always @(negedge clk) begin
    if (!mon_en) begin
      pv = vcode; pd = cdiv; pm = pmult;
    end else begin
      #1;
      if ((vcode != pv) && (cdiv != pd || pmult != pm)) joint = 1;
      if (first == 0 && vcode != pv) first = 1;
      else if (first == 0 && (cdiv != pd || pmult != pm)) first = 2;
      pv = vcode; pd = cdiv; pm = pmult;
      if (busy) busy_cnt++;
      if (done) begin
        if (sb_q.size() == 0) check(0, "R8 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(vcode == e.v, "R2/R3/R9 vcode", vcode, e.v);
          check(cdiv == e.d, "R4/R7 divider", cdiv, e.d);
          check(pmult == e.m, "R5 multiplier", pmult, e.m);
          check(err == e.e, "R7 error flag", err, e.e);
          check(busy_cnt == e.busy, "R4/R5/R6/R12 busy cycles", busy_cnt, e.busy);
          check(first == e.order, "R2/R3 first change", first, e.order);
          check(!joint, "R1 joint change", joint, 0);
          if (!e.e) check(lock == 1'b1, "R5 lock at done", lock, 1);
        end
        busy_cnt = 0; first = 0; joint = 0;
      end
    end
  end

  task automatic wr_entry(input int l, input int v, input int d, input int m);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 3'(l); tbl_v = VW'(v); tbl_d = DW'(d); tbl_m = MW'(m);
    @(negedge clk);
    tbl_we = 0;
    mv[l] = v; md[l] = d; mm[l] = m;
  endtask

  task automatic push_exp(input int l);
    exp_t e;
    int lx, t;
    bit ok;
    t = int'(tmo);
    ok = (settle_d <= t);
    lx = (mm[l] != cm) ? lock_d + 1 : 0;
    if (l == cur_l) e = '{cv, cd, cm, 0, 0, 0};
    else if (l > cur_l) begin
      if (ok) begin
        e = '{mv[l], md[l], mm[l], 0, settle_d + 3 + lx, 1};
        cv = mv[l]; cd = md[l]; cm = mm[l]; cur_l = l;
      end else begin
        e = '{mv[l], cd, cm, 1, t + 2, 1};
        cv = mv[l];
      end
    end else begin
      e = '{mv[l], md[l], mm[l], ok ? 0 : 1, (ok ? settle_d : t) + 3 + lx, 2};
      cv = mv[l]; cd = md[l]; cm = mm[l]; cur_l = l;
    end
    sb_q.push_back(e);
  endtask

  task automatic start_req(input int l);
    push_exp(l);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_level = 3'(l); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_req(input int l, input int sd, input int ld);
    settle_d = sd; lock_d = ld;
    start_req(l);
    wait_done();
  endtask

  initial begin
    fork
      begin
        for (int i = 0; i < LEVELS; i++) begin mv[i] = RV; md[i] = RD; mm[i] = RM; end
        #20;
        check(vcode == VW'(RV), "R10 reset vcode", vcode, RV);
        check(cdiv == DW'(RD), "R10 reset divider", cdiv, RD);
        check(pmult == MW'(RM), "R10 reset multiplier", pmult, RM);
        check(done == 1'b1, "R10 reset done", done, 1);
        check(req_ready == 1'b0 && err == 1'b0, "R10 reset ready/err", {req_ready, err}, 0);
        @(negedge clk); rst_n = 1;
        while (!req_ready) @(negedge clk);
        mon_en = 1;
        for (int i = 0; i < LEVELS; i++)
          wr_entry(i, 64 + 8 * i, 8 - (i % 4), (i < 4) ? 10 : 20);
        // R11: table write visible on later requests; R9: same level
        run_req(0, 2, 2);
        run_req(2, 3, 2);        // R2, R4 up, divider only
        run_req(5, 2, 4);        // R2, R5 up, PLL relock
        run_req(4, 5, 2);        // R3, R4 down, divider only
        run_req(1, 2, 3);        // R3, R5 down, PLL relock
        tmo = 8'd6;
        run_req(3, 6, 2);        // R6 settle in the limit cycle wins
        run_req(6, 7, 2);        // R7 up timeout, clock held
        run_req(3, 2, 2);        // R7 flag clears, R9 no change
        run_req(2, 100, 2);      // R7 down timeout, clock lowered
        tmo = 8'd12;
        // R11 snapshot: rewrite level 7 during its own transition
        settle_d = 4; lock_d = 2;
        start_req(7);
        wr_entry(7, 200, 3, 30);
        // R8: ready low while busy, held request not taken
        check(req_ready == 1'b0, "R8 ready while busy", req_ready, 0);
        req_level = 3'd0; req_valid = 1;
        while (!done) @(negedge clk);
        req_valid = 0;
        @(negedge clk); @(negedge clk);
        check(busy == 1'b0 && cdiv == DW'(cd), "R8 held request ignored", {busy, cdiv}, cd);
        run_req(5, 2, 2);
        run_req(7, 3, 2);        // R11 new entry now used
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R12 all transitions done", sb_q.size(), 0);
      end
      begin
        repeat (100000) @(posedge clk);
        check(0, "R12 watchdog done", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule